// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers completion, error and abort events from eight DMA channels and turns them into status registers and three interrupt lines. For every event class it keeps two views: a raw status, recording that the event happened, and an interrupt status, recording that the event is allowed to raise an interrupt. A completion can be suppressed from both views by a per-channel control mask. It can also be held out of the interrupt view alone by a per-channel interrupt mask. Error and abort events have their own interrupt masks.

Software reads the status through a simple register port, and clears status bits by writing ones to two clear registers. Error and abort flags share one register: error flags sit in the low byte and abort flags in the third byte. A summary register folds all three interrupt views into one byte, so one read shows which channels need service. The interrupt outputs are registered. The enable status of each channel, taken from its start bit, is also readable.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every status register reads 0 and all three interrupt outputs are 0.
- R2: A `done_ev[i]` pulse sets raw completion bit i (offset 0x14) unless `tc_ctl_mask[i]` is 1, in which case neither completion register changes.
- R3: Completion interrupt bit i (offset 0x04) is set only when raw bit i is being set and `tc_irq_mask[i]` is 0.
- R4: Error for channel i sets bit i, and abort for channel i sets bit 16+i, of the raw register at offset 0x18 unconditionally. They set the same bits of the interrupt register at offset 0x0C only when `err_irq_mask[i]` or `abt_irq_mask[i]` is 0, respectively.
- R5: A write to offset 0x08 clears the completion bits written as 1 in both 0x04 and 0x14. A write to offset 0x10 clears the written-1 bits (0..7 and 16..23) in both 0x0C and 0x18. Bits written as 0 are kept, and writes to any other offset change no state.
- R6: Offset 0x00 reads, in bits 7:0, the OR of completion interrupt bits, error interrupt bits and abort interrupt bits of each channel.
- R7: `irq_tc` is the OR of completion interrupt bits. `irq_err` is the OR of error and abort interrupt bits. `irq_any` is the OR of both. Each output changes one clock after the status change or clear that causes it.
- R8: When a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: Offset 0x1C reads `chan_start` in bits 7:0. The clear offsets and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_ev | input | 8 | Per-channel completion pulse |
| err_ev | input | 8 | Per-channel error pulse |
| abt_ev | input | 8 | Per-channel abort pulse |
| tc_ctl_mask | input | 8 | Per-channel completion suppress (both views) |
| tc_irq_mask | input | 8 | Per-channel completion interrupt mask |
| err_irq_mask | input | 8 | Per-channel error interrupt mask |
| abt_irq_mask | input | 8 | Per-channel abort interrupt mask |
| chan_start | input | 8 | Per-channel start bit, reflected at 0x1C |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_tc | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error/abort interrupt |
| irq_any | output | 1 | Combined interrupt |

## Verification
An event or clear sampled at clock edge k is visible in the status registers right after edge k, because reads are combinational from the registers. The interrupt outputs follow only after edge k+1. The bench drives every stimulus on the falling edge and reads status at the next falling edge. At that same point it confirms that the interrupt line still shows its old value, then checks the new value one falling edge later. This pins each result to its exact cycle rather than to an interval.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done_ev,
  input  logic [NCH-1:0] err_ev,
  input  logic [NCH-1:0] abt_ev,
  input  logic [NCH-1:0] tc_ctl_mask,
  input  logic [NCH-1:0] tc_irq_mask,
  input  logic [NCH-1:0] err_irq_mask,
  input  logic [NCH-1:0] abt_irq_mask,
  input  logic [NCH-1:0] chan_start,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq_tc,
  output logic           irq_err,
  output logic           irq_any
);
  localparam int ABT_LSB = 16;
  localparam logic [AW-1:0] A_SUM    = AW'(8'h00);
  localparam logic [AW-1:0] A_TC_INT = AW'(8'h04);
  localparam logic [AW-1:0] A_TC_CLR = AW'(8'h08);
  localparam logic [AW-1:0] A_EA_INT = AW'(8'h0C);
  localparam logic [AW-1:0] A_EA_CLR = AW'(8'h10);
  localparam logic [AW-1:0] A_TC_RAW = AW'(8'h14);
  localparam logic [AW-1:0] A_EA_RAW = AW'(8'h18);
  localparam logic [AW-1:0] A_ENA    = AW'(8'h1C);

  logic [NCH-1:0] tc_raw, tc_int, err_raw, err_int, abt_raw, abt_int;

  wire tc_clr_hit = reg_wr && (reg_addr == A_TC_CLR);
  wire ea_clr_hit = reg_wr && (reg_addr == A_EA_CLR);

  wire [NCH-1:0] tc_clr  = tc_clr_hit ? reg_wdata[NCH-1:0] : '0;
  wire [NCH-1:0] err_clr = ea_clr_hit ? reg_wdata[NCH-1:0] : '0;
  wire [NCH-1:0] abt_clr = ea_clr_hit ? reg_wdata[ABT_LSB +: NCH] : '0;

  wire [NCH-1:0] tc_set   = done_ev & ~tc_ctl_mask;
  wire [NCH-1:0] tc_iset  = tc_set & ~tc_irq_mask;
  wire [NCH-1:0] err_iset = err_ev & ~err_irq_mask;
  wire [NCH-1:0] abt_iset = abt_ev & ~abt_irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_raw  <= '0;
      tc_int  <= '0;
      err_raw <= '0;
      err_int <= '0;
      abt_raw <= '0;
      abt_int <= '0;
    end else begin
      tc_raw  <= (tc_raw  & ~tc_clr)  | tc_set;
      tc_int  <= (tc_int  & ~tc_clr)  | tc_iset;
      err_raw <= (err_raw & ~err_clr) | err_ev;
      err_int <= (err_int & ~err_clr) | err_iset;
      abt_raw <= (abt_raw & ~abt_clr) | abt_ev;
      abt_int <= (abt_int & ~abt_clr) | abt_iset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tc  <= 1'b0;
      irq_err <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      irq_tc  <= |tc_int;
      irq_err <= |{err_int, abt_int};
      irq_any <= |{tc_int, err_int, abt_int};
    end
  end

  logic [DW-1:0] ea_int_w, ea_raw_w;
  always_comb begin
    ea_int_w = '0;
    ea_raw_w = '0;
    ea_int_w[NCH-1:0]          = err_int;
    ea_int_w[ABT_LSB +: NCH]   = abt_int;
    ea_raw_w[NCH-1:0]          = err_raw;
    ea_raw_w[ABT_LSB +: NCH]   = abt_raw;
  end

  always_comb begin
    case (reg_addr)
      A_SUM:    reg_rdata = DW'(tc_int | err_int | abt_int);
      A_TC_INT: reg_rdata = DW'(tc_int);
      A_EA_INT: reg_rdata = ea_int_w;
      A_TC_RAW: reg_rdata = DW'(tc_raw);
      A_EA_RAW: reg_rdata = ea_raw_w;
      A_ENA:    reg_rdata = DW'(chan_start);
      default:  reg_rdata = '0;
    endcase
  end

  // R8
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |tc_set |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

  // R3
  tc_int_within_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_int & ~tc_raw) == '0);

  // R5
  ea_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_clr_hit && (err_ev == '0)) |=> ((err_raw & $past(reg_wdata[NCH-1:0])) == '0));

  // R7
  irq_tc_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq_tc == $past(|tc_int)));

  // R7
  irq_any_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_tc | irq_err));
endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] done_ev = '0, err_ev = '0, abt_ev = '0;
  logic [NCH-1:0] tc_ctl_mask = '0, tc_irq_mask = '0, err_irq_mask = '0, abt_irq_mask = '0;
  logic [NCH-1:0] chan_start = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_tc, irq_err, irq_any;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status u_dut (
    .clk(clk), .rst_n(rst_n),
    .done_ev(done_ev), .err_ev(err_ev), .abt_ev(abt_ev),
    .tc_ctl_mask(tc_ctl_mask), .tc_irq_mask(tc_irq_mask),
    .err_irq_mask(err_irq_mask), .abt_irq_mask(abt_irq_mask),
    .chan_start(chan_start),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // drive at negedge, sampled at next posedge, return at following negedge
  task automatic step(input logic [NCH-1:0] d, input logic [NCH-1:0] e, input logic [NCH-1:0] ab,
                      input logic wr, input logic [7:0] a, input logic [31:0] wd);
    done_ev = d; err_ev = e; abt_ev = ab;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    done_ev = '0; err_ev = '0; abt_ev = '0; reg_wr = 1'b0;
  endtask

  task automatic clear_all();
    step('0, '0, '0, 1'b1, 8'h08, 32'hFFFF_FFFF);
    step('0, '0, '0, 1'b1, 8'h10, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 sum", 8'h00, 0);
    rd_chk("R1 tc_int", 8'h04, 0);
    rd_chk("R1 ea_int", 8'h0C, 0);
    rd_chk("R1 tc_raw", 8'h14, 0);
    rd_chk("R1 ea_raw", 8'h18, 0);
    chk("R1 irqs", {29'd0, irq_tc, irq_err, irq_any}, 0);
  endtask

  task automatic t_tc_basic();
    step(8'h09, '0, '0, 1'b0, 8'h00, 0);
    rd_chk("R2 tc_raw", 8'h14, 32'h09);
    rd_chk("R3 tc_int", 8'h04, 32'h09);
    chk("R7 irq_tc not yet", irq_tc, 0);
    @(negedge clk);
    chk("R7 irq_tc", irq_tc, 1);
    chk("R7 irq_any", irq_any, 1);
    chk("R7 irq_err", irq_err, 0);
    clear_all();
  endtask

  task automatic t_tc_masks();
    tc_ctl_mask = 8'h02;
    tc_irq_mask = 8'h04;
    step(8'h06, '0, '0, 1'b0, 8'h00, 0);
    rd_chk("R2 ctl mask raw", 8'h14, 32'h04);
    rd_chk("R3 irq mask int", 8'h04, 32'h00);
    @(negedge clk);
    chk("R7 masked irq_tc", irq_tc, 0);
    tc_ctl_mask = '0;
    tc_irq_mask = '0;
    clear_all();
  endtask

  task automatic t_err_abt();
    abt_irq_mask = 8'h01;
    step('0, 8'h04, 8'h21, 1'b0, 8'h00, 0);
    rd_chk("R4 ea_raw lanes", 8'h18, 32'h0021_0004);
    rd_chk("R4 ea_int lanes", 8'h0C, 32'h0020_0004);
    rd_chk("R6 summary fold", 8'h00, 32'h24);
    @(negedge clk);
    chk("R7 irq_err", irq_err, 1);
    chk("R7 irq_tc quiet", irq_tc, 0);
    abt_irq_mask = '0;
  endtask

  task automatic t_clear();
    step(8'h81, '0, '0, 1'b0, 8'h00, 0);
    step('0, '0, '0, 1'b1, 8'h04, 32'hFFFF_FFFF);
    rd_chk("R5 other offset no effect", 8'h04, 32'h81);
    step('0, '0, '0, 1'b1, 8'h08, 32'h0000_0080);
    rd_chk("R5 tc int clear", 8'h04, 32'h01);
    rd_chk("R5 tc raw clear", 8'h14, 32'h01);
    step('0, '0, '0, 1'b1, 8'h10, 32'h0020_0000);
    rd_chk("R5 ea raw partial clear", 8'h18, 32'h0001_0004);
    step('0, '0, '0, 1'b1, 8'h10, 32'h0001_0004);
    rd_chk("R5 ea int clear", 8'h0C, 0);
    chk("R7 irq_err before lag", irq_err, 1);
    @(negedge clk);
    chk("R7 irq_err after clear", irq_err, 0);
    step('0, '0, '0, 1'b1, 8'h08, 32'h0000_0001);
    chk("R7 irq_tc before lag", irq_tc, 1);
    @(negedge clk);
    chk("R7 irq_tc after clear", irq_tc, 0);
    chk("R7 irq_any after clear", irq_any, 0);
  endtask

  task automatic t_collide();
    step(8'h10, '0, '0, 1'b0, 8'h00, 0);
    step(8'h10, '0, '0, 1'b1, 8'h08, 32'h0000_0010);
    rd_chk("R8 tc set wins", 8'h14, 32'h10);
    step('0, '0, 8'h02, 1'b1, 8'h10, 32'h0002_0000);
    rd_chk("R8 abort set wins", 8'h18, 32'h0002_0000);
    clear_all();
  endtask

  task automatic t_enable_map();
    chan_start = 8'hA5;
    rd_chk("R9 enable status", 8'h1C, 32'hA5);
    step(8'h01, '0, '0, 1'b0, 8'h00, 0);
    rd_chk("R9 clear offset reads 0", 8'h08, 0);
    rd_chk("R9 unmapped reads 0", 8'h24, 0);
    chan_start = '0;
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_tc_basic();
    t_tc_masks();
    t_err_abt();
    t_clear();
    t_collide();
    t_enable_map();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule